// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps in-flight instructions in program order between the point where they are issued and the point where their results become architectural. Issue claims the entry at the allocation pointer, stores the instruction's class and destination register in it, and gets that entry's index back as a tag. Execution units later report results by tag, in any order. A result may also carry a fault flag or a mispredicted-branch flag.

Only the oldest entry can leave the buffer. When the oldest entry has a plain result, it is presented on the register-file write port in that same cycle and removed at the clock edge. When the oldest entry carries a fault or a mispredict flag, it is not written to the register file. Instead the block emits a one-cycle flush pulse, which also goes to the rename table. For a fault it also emits an exception pulse. At the next edge the buffer becomes empty: the allocation pointer is moved back onto the retirement pointer. Because of this, a fault on a younger, wrong-path instruction is thrown away without ever being reported.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer reports empty=1 and full=0, commit_valid, flush and exc_raise are all 0, and alloc_tag is 0.
- R2: Each granted allocation returns alloc_tag equal to the current allocation pointer, which then advances by one and wraps from 7 to 0.
- R3: After eight allocations with no retirement, full is 1, and a request made while full and no retirement is happening gets alloc_ok=0.
- R4: A writeback (wb_valid with wb_tag) marks the addressed live entry finished and stores wb_data, wb_exc and wb_mispred in it. A writeback to an entry that is not live has no effect: a later allocation of that entry does not retire until it receives its own writeback.
- R5: When the oldest entry is finished with neither flag set, commit_valid is 1 in that same cycle, with commit_tag, commit_dst, commit_opc and commit_data taken from that entry. At most one entry retires per cycle.
- R6: A finished entry does not retire while any older entry is still unfinished. Once the older entry finishes, the waiting entries retire in program order, one per cycle.
- R7: When the oldest entry is finished with wb_mispred=1, flush is 1 for exactly that cycle and commit_valid is 0. After that edge, empty=1 and alloc_tag equals the branch's tag.
- R8: When the oldest entry is finished with wb_exc=1, exc_raise and flush are both 1 and commit_valid is 0. The buffer is then empty, as in R7.
- R9: A younger entry marked with wb_exc=1 that is discarded by an older mispredict flush never causes exc_raise=1.
- R10: When the buffer is full and the oldest entry retires in a given cycle, an allocation request in that cycle is granted and takes the freed tag, and full stays 1.
- R11: During a flush cycle alloc_ok is 0, even if alloc_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_req | input | 1 | Issue asks for an entry |
| alloc_opc | input | 3 | Instruction class stored in the entry |
| alloc_dst | input | 5 | Destination architectural register |
| alloc_ok | output | 1 | Allocation granted this cycle |
| alloc_tag | output | 3 | Tag of the entry that the next allocation takes |
| full | output | 1 | All eight entries are live |
| empty | output | 1 | No entry is live |
| wb_valid | input | 1 | A result is being reported |
| wb_tag | input | 3 | Entry that the result belongs to |
| wb_data | input | 32 | Result value |
| wb_exc | input | 1 | Instruction faulted |
| wb_mispred | input | 1 | Branch was mispredicted |
| commit_valid | output | 1 | Register-file write enable for the retiring entry |
| commit_tag | output | 3 | Tag of the oldest entry |
| commit_dst | output | 5 | Register written at retirement |
| commit_opc | output | 3 | Class of the retiring instruction |
| commit_data | output | 32 | Value written at retirement |
| flush | output | 1 | One-cycle pulse: buffer discarded, rename table must reset |
| exc_raise | output | 1 | One-cycle pulse: the oldest entry faulted |

## Verification
The hardest case to reach from the ports is the buffer being full at the same moment as the oldest entry retires and a new request arrives. In that cycle the freed tag and the allocated tag are the same index.

The bench reaches it in a fixed order. It fills all eight entries and reports results for every entry except the oldest, in reverse order, so nothing can retire. It then finishes the oldest entry and raises a request in the very cycle that entry retires.

The phantom-fault case is reached in a similar way. A fault is reported on a younger entry first, and only afterwards does the older branch resolve as mispredicted.

// File: rtl/rob_pkg.sv
// Shared types for the reorder buffer.
// Assumes: nothing beyond standard SystemVerilog.
package rob_pkg;

    // What the oldest entry does in the current cycle
    typedef enum logic [1:0] {
        HD_WAIT    = 2'd0,  // empty or unfinished: nothing leaves
        HD_RETIRE  = 2'd1,  // normal result written to register file
        HD_BRFLUSH = 2'd2,  // mispredicted branch: discard everything
        HD_EXFLUSH = 2'd3   // faulting instruction: discard and raise
    } head_act_e;

endpackage

// File: rtl/rob_ptr_ctrl.sv
// Pointer and occupancy control for the reorder buffer.
// Keeps the allocation (tail) and retirement (head) pointers plus an
// occupancy count that separates full from empty when the pointers meet.
// Assumes: DEPTH is a power of two, so pointers wrap by overflow.
// A flush has priority and moves tail onto head.
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_alloc,
    input  logic             do_retire,
    input  logic             do_flush,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic             full,
    output logic             empty
);

    logic [CNT_W-1:0] count_q;

    // Advance pointers and occupancy; flush collapses the buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head    <= '0;
            tail    <= '0;
            count_q <= '0;
        end else if (do_flush) begin
            tail    <= head;
            count_q <= '0;
        end else begin
            if (do_alloc)  tail <= tail + TAG_W'(1);
            if (do_retire) head <= head + TAG_W'(1);
            count_q <= count_q + CNT_W'(do_alloc) - CNT_W'(do_retire);
        end
    end

    // Occupancy flags
    always_comb begin
        full  = (count_q == CNT_W'(DEPTH));
        empty = (count_q == '0);
    end

endmodule

// File: rtl/rob_entry_array.sv
// Entry storage for the reorder buffer.
// Each entry holds live/finished/fault/mispredict flags plus destination,
// class and result. Writebacks are accepted by index only for live entries.
// Assumes: the controller never allocates into a live entry unless that
// entry retires in the same cycle.
module rob_entry_array #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int OPC_W  = 3,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  logic [OPC_W-1:0]  alloc_opc,
    input  logic [REG_W-1:0]  alloc_dst,
    input  logic              wb_en,
    input  logic [TAG_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              wb_exc,
    input  logic              wb_mis,
    input  logic              retire_en,
    input  logic              flush_en,
    input  logic [TAG_W-1:0]  head_idx,
    output logic              head_valid,
    output logic              head_done,
    output logic              head_exc,
    output logic              head_mis,
    output logic [REG_W-1:0]  head_dst,
    output logic [OPC_W-1:0]  head_opc,
    output logic [DATA_W-1:0] head_data
);

    logic [DEPTH-1:0] valid_v, done_v, exc_v, mis_v;
    logic [REG_W-1:0]  dst_v  [DEPTH];
    logic [OPC_W-1:0]  opc_v  [DEPTH];
    logic [DATA_W-1:0] data_v [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic              e_valid, e_done, e_exc, e_mis;
        logic [REG_W-1:0]  e_dst;
        logic [OPC_W-1:0]  e_opc;
        logic [DATA_W-1:0] e_data;
        logic              hit_alloc, hit_wb, hit_ret;

        // Per-entry index decode
        always_comb begin
            hit_alloc = alloc_en && (alloc_idx == TAG_W'(i));
            hit_wb    = wb_en && (wb_idx == TAG_W'(i)) && e_valid;
            hit_ret   = retire_en && (head_idx == TAG_W'(i));
        end

        // Status flags: allocation wins over same-cycle retirement
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_valid <= 1'b0;
                e_done  <= 1'b0;
                e_exc   <= 1'b0;
                e_mis   <= 1'b0;
            end else if (flush_en) begin
                e_valid <= 1'b0;
            end else if (hit_alloc) begin
                e_valid <= 1'b1;
                e_done  <= 1'b0;
                e_exc   <= 1'b0;
                e_mis   <= 1'b0;
            end else if (hit_ret) begin
                e_valid <= 1'b0;
            end else if (hit_wb) begin
                e_done <= 1'b1;
                e_exc  <= wb_exc;
                e_mis  <= wb_mis;
            end
        end

        // Payload capture, no reset needed since flags gate its use
        always_ff @(posedge clk) begin
            if (hit_alloc) begin
                e_dst <= alloc_dst;
                e_opc <= alloc_opc;
            end
            if (hit_wb && !hit_alloc) e_data <= wb_data;
        end

        assign valid_v[i] = e_valid;
        assign done_v[i]  = e_done;
        assign exc_v[i]   = e_exc;
        assign mis_v[i]   = e_mis;
        assign dst_v[i]   = e_dst;
        assign opc_v[i]   = e_opc;
        assign data_v[i]  = e_data;
    end

    // Oldest-entry read mux
    always_comb begin
        head_valid = valid_v[head_idx];
        head_done  = done_v[head_idx];
        head_exc   = exc_v[head_idx];
        head_mis   = mis_v[head_idx];
        head_dst   = dst_v[head_idx];
        head_opc   = opc_v[head_idx];
        head_data  = data_v[head_idx];
    end

endmodule

// File: rtl/rob_commit_ctrl.sv
// Retirement decision for the oldest entry and allocation grant.
// Purely combinational. Assumes the head flags come from the entry array.
// Fault takes priority over mispredict when both are set.
module rob_commit_ctrl
    import rob_pkg::*;
(
    input  logic head_valid,
    input  logic head_done,
    input  logic head_exc,
    input  logic head_mis,
    input  logic alloc_req,
    input  logic full,
    output logic retire,
    output logic flush,
    output logic exc_raise,
    output logic alloc_ok
);

    head_act_e act;

    // Classify what the oldest entry does this cycle
    always_comb begin
        if (!(head_valid && head_done)) act = HD_WAIT;
        else if (head_exc)              act = HD_EXFLUSH;
        else if (head_mis)              act = HD_BRFLUSH;
        else                            act = HD_RETIRE;
    end

    // Decode actions and grant allocation when a slot is or becomes free
    always_comb begin
        retire    = (act == HD_RETIRE);
        flush     = (act == HD_BRFLUSH) || (act == HD_EXFLUSH);
        exc_raise = (act == HD_EXFLUSH);
        alloc_ok  = alloc_req && !flush && (!full || retire);
    end

endmodule

// File: rtl/rob_core.sv
// Reorder buffer top: in-order allocation, out-of-order writeback by tag,
// in-order retirement to one register-file write port, and a full discard
// when a faulting or mispredicted entry becomes oldest.
// Assumes: one allocation, one writeback and one retirement per cycle at most.
module rob_core #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int OPC_W  = 3,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [OPC_W-1:0]  alloc_opc,
    input  logic [REG_W-1:0]  alloc_dst,
    output logic              alloc_ok,
    output logic [TAG_W-1:0]  alloc_tag,
    output logic              full,
    output logic              empty,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              wb_exc,
    input  logic              wb_mispred,
    output logic              commit_valid,
    output logic [TAG_W-1:0]  commit_tag,
    output logic [REG_W-1:0]  commit_dst,
    output logic [OPC_W-1:0]  commit_opc,
    output logic [DATA_W-1:0] commit_data,
    output logic              flush,
    output logic              exc_raise
);

    logic [TAG_W-1:0] head, tail;
    logic h_valid, h_done, h_exc, h_mis, retire;

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .do_alloc(alloc_ok), .do_retire(retire), .do_flush(flush),
        .head(head), .tail(tail), .full(full), .empty(empty)
    );

    rob_entry_array #(
        .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .OPC_W(OPC_W)
    ) u_arr (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_ok), .alloc_idx(tail),
        .alloc_opc(alloc_opc), .alloc_dst(alloc_dst),
        .wb_en(wb_valid), .wb_idx(wb_tag), .wb_data(wb_data),
        .wb_exc(wb_exc), .wb_mis(wb_mispred),
        .retire_en(retire), .flush_en(flush), .head_idx(head),
        .head_valid(h_valid), .head_done(h_done),
        .head_exc(h_exc), .head_mis(h_mis),
        .head_dst(commit_dst), .head_opc(commit_opc), .head_data(commit_data)
    );

    rob_commit_ctrl u_cmt (
        .head_valid(h_valid), .head_done(h_done),
        .head_exc(h_exc), .head_mis(h_mis),
        .alloc_req(alloc_req), .full(full),
        .retire(retire), .flush(flush), .exc_raise(exc_raise),
        .alloc_ok(alloc_ok)
    );

    // Expose pointers and the write enable
    always_comb begin
        alloc_tag    = tail;
        commit_tag   = head;
        commit_valid = retire;
    end

endmodule

// File: rtl/rob_core_checker.sv
// Temporal checks on the reorder buffer ports, bound to rob_core.
// Assumes: synchronous active-low reset.
module rob_core_checker #(
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_req,
    input logic             alloc_ok,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             full,
    input logic             empty,
    input logic             commit_valid,
    input logic             flush,
    input logic             exc_raise
);

    p_flags_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_block_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !commit_valid) |-> !alloc_ok);

    p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok |-> alloc_req);

    p_tag_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_ok && !flush) |=> (alloc_tag == $past(alloc_tag) + TAG_W'(1)));

    p_empty_no_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !commit_valid);

    p_flush_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !commit_valid);

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !flush));

    p_exc_flushes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_raise |-> flush);

    p_no_alloc_in_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !alloc_ok);

endmodule

bind rob_core rob_core_checker #(.TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_ok(alloc_ok),
    .alloc_tag(alloc_tag), .full(full), .empty(empty),
    .commit_valid(commit_valid), .flush(flush), .exc_raise(exc_raise)
);

// File: tb/tb_rob_core.sv
// Directed bench for rob_core: one task per scenario, each checking itself.
module tb_rob_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic [2:0]  alloc_opc = '0;
    logic [4:0]  alloc_dst = '0;
    logic        alloc_ok;
    logic [2:0]  alloc_tag;
    logic        full, empty;
    logic        wb_valid = 1'b0;
    logic [2:0]  wb_tag = '0;
    logic [31:0] wb_data = '0;
    logic        wb_exc = 1'b0;
    logic        wb_mispred = 1'b0;
    logic        commit_valid;
    logic [2:0]  commit_tag;
    logic [4:0]  commit_dst;
    logic [2:0]  commit_opc;
    logic [31:0] commit_data;
    logic        flush, exc_raise;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] nt = '0;   // expected next allocation tag
    logic [2:0] hd = '0;   // expected oldest tag

    always #2 clk = ~clk;  // 250 MHz

    rob_core dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_opc(alloc_opc), .alloc_dst(alloc_dst),
        .alloc_ok(alloc_ok), .alloc_tag(alloc_tag), .full(full), .empty(empty),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .wb_exc(wb_exc), .wb_mispred(wb_mispred),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .commit_dst(commit_dst), .commit_opc(commit_opc),
        .commit_data(commit_data), .flush(flush), .exc_raise(exc_raise)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Allocate one entry; expects a grant with the predicted tag
    task automatic do_alloc(input logic [4:0] dst, input logic [2:0] opc);
        alloc_req = 1'b1; alloc_dst = dst; alloc_opc = opc;
        #1;
        check("R2 grant", alloc_ok, 1);
        check("R2 tag", alloc_tag, nt);
        step();
        alloc_req = 1'b0;
        nt = nt + 3'd1;
    endtask

    // Report one result for one cycle
    task automatic do_wb(input logic [2:0] tag, input logic [31:0] d,
                         input logic ex, input logic mp);
        wb_valid = 1'b1; wb_tag = tag; wb_data = d; wb_exc = ex; wb_mispred = mp;
        step();
        wb_valid = 1'b0; wb_exc = 1'b0; wb_mispred = 1'b0;
    endtask

    // Expect the oldest entry to retire now, then let the edge pass
    task automatic expect_commit(input string req, input logic [2:0] tag,
                                 input logic [4:0] dst, input logic [31:0] d);
        #1;
        check(req, commit_valid, 1);
        check(req, commit_tag, tag);
        check(req, commit_dst, dst);
        check(req, commit_data, d);
        step();
        hd = hd + 3'd1;
    endtask

    task automatic t_reset();
        #1;
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 commit", commit_valid, 0);
        check("R1 flush", flush, 0);
        check("R1 exc", exc_raise, 0);
        check("R1 tag", alloc_tag, 0);
    endtask

    // R5/R6: out-of-order results, in-order retirement
    task automatic t_in_order();
        logic [2:0] b = nt;
        do_alloc(5'd1, 3'd1);
        do_alloc(5'd2, 3'd1);
        do_alloc(5'd3, 3'd1);
        do_wb(b + 3'd2, 32'hC2, 1'b0, 1'b0);
        #1 check("R6 younger waits", commit_valid, 0);
        do_wb(b + 3'd1, 32'hC1, 1'b0, 1'b0);
        #1 check("R6 younger waits", commit_valid, 0);
        do_wb(b, 32'hC0, 1'b0, 1'b0);
        #1 check("R5 opc", commit_opc, 1);
        expect_commit("R5 head", b, 5'd1, 32'hC0);
        expect_commit("R6 order", b + 3'd1, 5'd2, 32'hC1);
        expect_commit("R6 order", b + 3'd2, 5'd3, 32'hC2);
        #1 check("R5 drained", empty, 1);
        check("R5 one per cycle", commit_valid, 0);
    endtask

    // R3/R10: fill, refuse, then allocate into the slot freed this cycle
    task automatic t_full();
        logic [2:0] b = nt;
        for (int k = 0; k < 8; k++) do_alloc(5'(k + 8), 3'd2);
        #1 check("R3 full", full, 1);
        alloc_req = 1'b1;
        #1 check("R3 refused", alloc_ok, 0);
        alloc_req = 1'b0;
        for (int k = 7; k >= 1; k--) do_wb(b + 3'(k), 32'h100 + k, 1'b0, 1'b0);
        #1 check("R6 blocked", commit_valid, 0);
        do_wb(b, 32'h100, 1'b0, 1'b0);
        alloc_req = 1'b1; alloc_dst = 5'd30; alloc_opc = 3'd5;
        #1;
        check("R10 retire", commit_valid, 1);
        check("R10 grant", alloc_ok, 1);
        check("R10 tag", alloc_tag, b);
        step();
        alloc_req = 1'b0;
        hd = hd + 3'd1; nt = nt + 3'd1;
        #1 check("R10 still full", full, 1);
        for (int k = 1; k < 8; k++)
            expect_commit("R6 drain", b + 3'(k), 5'(k + 8), 32'h100 + k);
        #1 check("R6 unfinished waits", commit_valid, 0);
        do_wb(b, 32'h777, 1'b0, 1'b0);
        expect_commit("R10 new entry", b, 5'd30, 32'h777);
        #1 check("R10 drained", empty, 1);
    endtask

    // R4: result to a free slot is dropped
    task automatic t_stale_wb();
        logic [2:0] b = nt;
        do_wb(b, 32'hDEAD, 1'b0, 1'b0);
        do_alloc(5'd7, 3'd3);
        #1 check("R4 ignored", commit_valid, 0);
        step();
        #1 check("R4 ignored", commit_valid, 0);
        do_wb(b, 32'h55, 1'b0, 1'b0);
        expect_commit("R4 own result", b, 5'd7, 32'h55);
    endtask

    // R7/R11: mispredict at head discards everything
    task automatic t_mispredict();
        logic [2:0] b = nt;
        do_alloc(5'd4, 3'd6);
        do_alloc(5'd5, 3'd1);
        do_alloc(5'd6, 3'd1);
        do_wb(b + 3'd1, 32'h11, 1'b0, 1'b0);
        do_wb(b + 3'd2, 32'h12, 1'b0, 1'b0);
        do_wb(b, 32'h0, 1'b0, 1'b1);
        alloc_req = 1'b1;
        #1;
        check("R7 flush", flush, 1);
        check("R7 no write", commit_valid, 0);
        check("R7 no exc", exc_raise, 0);
        check("R11 no grant", alloc_ok, 0);
        step();
        alloc_req = 1'b0;
        #1;
        check("R7 empty", empty, 1);
        check("R7 pulse", flush, 0);
        check("R7 tag", alloc_tag, b);
        check("R7 no write after", commit_valid, 0);
        nt = b;
    endtask

    // R9: younger fault behind a mispredict is silent
    task automatic t_phantom();
        logic [2:0] b = nt;
        do_alloc(5'd9, 3'd6);
        do_alloc(5'd10, 3'd4);
        do_wb(b + 3'd1, 32'h0, 1'b1, 1'b0);
        #1 check("R9 not raised early", exc_raise, 0);
        do_wb(b, 32'h0, 1'b0, 1'b1);
        #1;
        check("R9 flush", flush, 1);
        check("R9 silent", exc_raise, 0);
        step();
        #1;
        check("R9 silent after", exc_raise, 0);
        check("R9 empty", empty, 1);
        nt = b;
    endtask

    // R8: fault at head raises exception and discards
    task automatic t_fault();
        logic [2:0] b = nt;
        do_alloc(5'd12, 3'd4);
        do_alloc(5'd13, 3'd1);
        do_wb(b + 3'd1, 32'h44, 1'b0, 1'b0);
        do_wb(b, 32'h0, 1'b1, 1'b0);
        #1;
        check("R8 raise", exc_raise, 1);
        check("R8 flush", flush, 1);
        check("R8 no write", commit_valid, 0);
        step();
        #1;
        check("R8 empty", empty, 1);
        check("R8 tag", alloc_tag, b);
        check("R8 pulse", exc_raise, 0);
        nt = b;
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_in_order();
        t_full();
        t_stale_wb();
        t_mispredict();
        t_phantom();
        t_fault();
        t_in_order();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule